// File: doc/BRIEF.md
# Presettable Up/Down Binary Counter With Cascade Outputs

This block is a synchronous binary counter whose width is a parameter (four bits by default). On each rising clock edge it steps up or down by one when its active-low count enable is asserted. A direction input chooses the stepping sense. The count wraps around at both ends of its range.

An active-low preload forces the count to a parallel data word at once, with no clock edge needed. While the preload is held, the clock is ignored. An active-low asynchronous reset clears the count, and its release is synchronised to the clock.

Two outputs let several counters be chained. A terminal flag goes high at the end of the range in the current direction: all ones when counting up, all zeros when counting down. A ripple output, active low, pulses during the low phase of the clock when that end is reached and counting is enabled. To build a wider counter on a shared clock, feed the ripple output of one stage into the count enable of the next stage.

Top module: `updn_counter`

## Requirements
- R1: With the count enable low and the direction input low, each rising clock edge increases the count by one.
- R2: With the count enable low and the direction input high, each rising clock edge decreases the count by one.
- R3: The count wraps in both directions: all ones plus one gives zero, and zero minus one gives all ones.
- R4: With the count enable high, clock edges leave the count unchanged.
- R5: Changing the count enable or the direction input between two clock edges does not change the count until the next rising edge.
- R6: Driving the preload input low makes the count equal the data input at once, with no clock edge.
- R7: While the preload input is low, clock edges do not change the count. After the preload is released (with the data held steady), counting continues from the loaded value.
- R8: The terminal flag is high exactly when the direction is low and the count is all ones, or the direction is high and the count is zero. The count enable has no effect on it.
- R9: The ripple output is low only while the clock is low, the count enable is low and the terminal flag is high. Otherwise it is high.
- R10: Two stages on one clock, with the ripple output of the low stage driving the count enable of the high stage, count through every value of the double-width range without skipping or repeating a value, both up and down.
- R11: A low level on the reset input clears the count to zero. Counting starts only after the release has passed a two-stage synchroniser.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low, released synchronously |
| cnt_en_n | input | 1 | Count enable, active low |
| dir_dn | input | 1 | Direction: 0 counts up, 1 counts down |
| load_n | input | 1 | Asynchronous preload, active low |
| din | input | W | Preload data word |
| cnt_q | output | W | Current count |
| tc_flag | output | 1 | Terminal count for the current direction |
| rco_n | output | 1 | Ripple output, active low, only during the low clock phase |

## Verification
The stepping assertions assume that the count enable and direction inputs are steady around each rising edge. They also assume that the preload data does not change while the preload is held low, because the stored value is captured only when the preload falls and at clock edges. The checker excludes any clock interval that contains a preload pulse by counting falling edges of the preload.

The bench follows these assumptions. It changes every input one nanosecond after a rising edge, during the high clock phase, and keeps the data word constant across each preload window. It checks the ripple output in both clock phases separately.

// File: rtl/updn_pkg.sv
`timescale 1ns/1ps
package updn_pkg;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;

  localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/updn_rst_sync.sv
`timescale 1ns/1ps
module updn_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/updn_en_hold.sv
`timescale 1ns/1ps
module updn_en_hold (
  input  logic clk,
  input  logic en_n_in,
  output logic en_n_held
);

  always_latch begin
    if (!clk) begin
      en_n_held <= en_n_in;
    end
  end

endmodule

// File: rtl/updn_next.sv
`timescale 1ns/1ps
module updn_next #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] cur,
  input  logic         dir_dn,
  output logic [W-1:0] nxt
);

  logic [W-1:0] flip;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_lsb
      assign flip[i] = 1'b1;
    end else begin : g_upper
      assign flip[i] = dir_dn ? ~|cur[i-1:0] : &cur[i-1:0];
    end
  end

  assign nxt = cur ^ flip;

endmodule

// File: rtl/updn_tc.sv
`timescale 1ns/1ps
module updn_tc #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic [W-1:0] cur,
  input  logic         dir_dn,
  input  logic         en_n,
  output logic         tc_flag,
  output logic         rco_n
);

  logic at_top;
  logic at_bottom;
  logic at_end;

  always_comb begin
    at_top    = &cur;
    at_bottom = ~|cur;
    at_end    = dir_dn ? at_bottom : at_top;
  end

  assign tc_flag = at_end;
  assign rco_n   = ~(at_end & ~en_n & ~clk);

endmodule

// File: rtl/updn_counter.sv
`timescale 1ns/1ps
module updn_counter #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en_n,
  input  logic         dir_dn,
  input  logic         load_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] cnt_q,
  output logic         tc_flag,
  output logic         rco_n
);

  import updn_pkg::*;

  logic         rst_sync_n;
  logic         en_n_held;
  logic         step_en;
  logic [W-1:0] cnt_r;
  logic [W-1:0] cnt_nxt;

  updn_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  updn_en_hold u_en (
    .clk       (clk),
    .en_n_in   (cnt_en_n),
    .en_n_held (en_n_held)
  );

  updn_next #(.W(W)) u_next (
    .cur    (cnt_r),
    .dir_dn (dir_dn),
    .nxt    (cnt_nxt)
  );

  assign step_en = ~en_n_held;

  always_ff @(posedge clk or negedge rst_sync_n or negedge load_n) begin
    if (!rst_sync_n) begin
      cnt_r <= '0;
    end else if (!load_n) begin
      cnt_r <= din;
    end else if (step_en) begin
      cnt_r <= cnt_nxt;
    end
  end

  assign cnt_q = (rst_sync_n && !load_n) ? din : cnt_r;

  updn_tc #(.W(W)) u_tc (
    .clk     (clk),
    .cur     (cnt_q),
    .dir_dn  (dir_dn),
    .en_n    (cnt_en_n),
    .tc_flag (tc_flag),
    .rco_n   (rco_n)
  );

endmodule

// File: rtl/updn_counter_chk.sv
`timescale 1ns/1ps
module updn_counter_chk #(
  parameter int unsigned W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rst_sync_n,
  input logic         cnt_en_n,
  input logic         dir_dn,
  input logic         load_n,
  input logic [W-1:0] din,
  input logic [W-1:0] cnt_q,
  input logic         tc_flag
);

  logic [1:0] ld_seen;

  always_ff @(negedge load_n or negedge rst_n) begin
    if (!rst_n) begin
      ld_seen <= '0;
    end else begin
      ld_seen <= ld_seen + 2'd1;
    end
  end

  assert_step_up_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && load_n && $past(load_n) && $stable(ld_seen)
     && !$past(cnt_en_n) && !$past(dir_dn))
    |-> cnt_q == W'($past(cnt_q) + 1'b1));

  assert_step_down_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && load_n && $past(load_n) && $stable(ld_seen)
     && !$past(cnt_en_n) && $past(dir_dn))
    |-> cnt_q == W'($past(cnt_q) - 1'b1));

  assert_wrap_up_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && load_n && $past(load_n) && $stable(ld_seen)
     && !$past(cnt_en_n) && !$past(dir_dn) && ($past(cnt_q) == '1))
    |-> cnt_q == '0);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && load_n && $past(load_n) && $stable(ld_seen)
     && $past(cnt_en_n))
    |-> $stable(cnt_q));

  assert_load_freeze_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && !load_n && !$past(load_n) && $stable(din))
    |-> $stable(cnt_q));

  assert_tc_top_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tc_flag && !dir_dn) |-> (cnt_q == '1));

  assert_tc_bottom_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tc_flag && dir_dn) |-> (cnt_q == '0));

endmodule

bind updn_counter updn_counter_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_sync_n (rst_sync_n),
  .cnt_en_n   (cnt_en_n),
  .dir_dn     (dir_dn),
  .load_n     (load_n),
  .din        (din),
  .cnt_q      (cnt_q),
  .tc_flag    (tc_flag)
);

// File: tb/sim_updn_counter.sv
`timescale 1ns/1ps
module sim_updn_counter;

  localparam int W = 4;
  localparam int M = 1 << W;

  logic         clk;
  logic         rst_n;
  logic         en0_n;
  logic         dir_dn;
  logic         load_n;
  logic [W-1:0] din0;
  logic [W-1:0] din1;
  logic [W-1:0] q0;
  logic [W-1:0] q1;
  logic         tc0;
  logic         tc1;
  logic         rco0_n;
  logic         rco1_n;

  int checks;
  int fails;
  bit done;

  updn_counter #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .cnt_en_n(en0_n), .dir_dn(dir_dn),
    .load_n(load_n), .din(din0), .cnt_q(q0), .tc_flag(tc0), .rco_n(rco0_n)
  );

  updn_counter #(.W(W)) u1 (
    .clk(clk), .rst_n(rst_n), .cnt_en_n(rco0_n), .dir_dn(dir_dn),
    .load_n(load_n), .din(din1), .cnt_q(q1), .tc_flag(tc1), .rco_n(rco1_n)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic preload(input int v0, input int v1);
    din0 = W'(v0);
    din1 = W'(v1);
    load_n = 1'b0;
    #0.5;
    chk("R6", int'(q0), v0);
    load_n = 1'b1;
    #0.2;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    int exp;
    checks = 0; fails = 0; done = 0;
    rst_n = 1'b0; en0_n = 1'b1; dir_dn = 1'b0; load_n = 1'b1;
    din0 = '0; din1 = '0;
    #11;
    chk("R11", int'(q0), 0);
    rst_n = 1'b1;
    tick(); tick(); tick();
    chk("R11", int'(q0), 0);
    chk("R8", int'(tc0), 0);

    // R1, R3: up sweep through the wrap
    en0_n = 1'b0; dir_dn = 1'b0;
    exp = 0;
    for (int i = 0; i < 20; i++) begin
      tick();
      exp = (exp + 1) % M;
      chk("R1/R3 up", int'(q0), exp);
    end

    // R2, R3: down sweep through the wrap
    dir_dn = 1'b1;
    for (int i = 0; i < 20; i++) begin
      tick();
      exp = (exp + M - 1) % M;
      chk("R2/R3 down", int'(q0), exp);
    end

    // R4: enable high holds
    en0_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R4", int'(q0), exp);
    end

    // R5: control change between edges has no immediate effect
    en0_n = 1'b0; dir_dn = 1'b0;
    tick();
    exp = (exp + 1) % M;
    chk("R5", int'(q0), exp);
    #0.5;
    dir_dn = 1'b1;
    #1;
    chk("R5", int'(q0), exp);
    tick();
    exp = (exp + M - 1) % M;
    chk("R5", int'(q0), exp);

    // R6, R7: load priority and resume
    din0 = 4'd9; dir_dn = 1'b0; en0_n = 1'b0;
    load_n = 1'b0;
    #0.5;
    chk("R6", int'(q0), 9);
    tick(); tick();
    chk("R7", int'(q0), 9);
    load_n = 1'b1;
    #0.2;
    chk("R7", int'(q0), 9);
    tick();
    chk("R7", int'(q0), 10);
    preload(3, 0);
    chk("R6", int'(q0), 3);
    tick();
    chk("R7", int'(q0), 4);

    // R8: exhaustive terminal flag, enable held high
    en0_n = 1'b1;
    for (int v = 0; v < M; v++) begin
      for (int d = 0; d < 2; d++) begin
        tick();
        dir_dn = d[0];
        preload(v, 0);
        chk("R8", int'(tc0), ((d == 0 && v == M - 1) || (d == 1 && v == 0)) ? 1 : 0);
      end
    end

    // R9: ripple output gating
    tick();
    dir_dn = 1'b0; en0_n = 1'b1;
    preload(M - 1, 0);
    @(negedge clk); #1;
    chk("R9 enable high", int'(rco0_n), 1);
    chk("R8 enable high", int'(tc0), 1);
    tick();
    en0_n = 1'b0;
    #0.3;
    chk("R9 clock high", int'(rco0_n), 1);
    @(negedge clk); #1;
    chk("R9 clock low", int'(rco0_n), 0);
    tick();
    chk("R9 after wrap", int'(q0), 0);
    @(negedge clk); #1;
    chk("R9 not terminal", int'(rco0_n), 1);
    tick();
    en0_n = 1'b1; dir_dn = 1'b1;
    preload(M - 1, 0);
    @(negedge clk); #1;
    chk("R9 wrong direction", int'(rco0_n), 1);

    // R10: cascaded pair, up then down
    tick();
    dir_dn = 1'b0;
    preload(0, 0);
    en0_n = 1'b0;
    exp = 0;
    for (int i = 0; i < M * M + 40; i++) begin
      tick();
      exp = (exp + 1) % (M * M);
      chk("R10 up", int'({q1, q0}), exp);
    end
    dir_dn = 1'b1;
    for (int i = 0; i < M * M + 40; i++) begin
      tick();
      exp = (exp + M * M - 1) % (M * M);
      chk("R10 down", int'({q1, q0}), exp);
    end

    done = 1;
    finish_run();
  end

endmodule